// File: doc/BRIEF.md
# Byte-Wide Asynchronous Register Port

This block connects a host that drives a static-RAM style bus to a register space of 64 bytes. The host drives a 6-bit address, an 8-bit data bus and three active-low strobes: chip select, output enable and write enable. The block brings these strobes into the system clock through a short synchronizer chain. It keeps 50 bytes of general-purpose storage at addresses 0x0E to 0x3F. Accesses to the lower 14 addresses go to the surrounding timekeeping core.

A write takes effect once, when the overlap of chip select and write enable ends. For the lower addresses the block emits a one-cycle write pulse that carries a class code for the register. Reads of the lower addresses return a byte that the core supplies for the synchronized address. The data pad is split into input, output and output-enable signals for the pad ring.

A power-good input guards the port. While power is bad, the block ignores every host input. After power returns, protection stays on for a set number of clock cycles.

Top module: `hbus_regport`

## Requirements
- R1: During reset and right after it, `bus_dq_oe` and `wr_valid` are low. Once protection has cleared, every storage byte reads back as 0x00.
- R2: A read is active while chip select and output enable are low and write enable is high. SYNC_STAGES+1 cycles later, `bus_dq_oe` is high and `bus_dq_o` carries the addressed byte. For addresses below 0x0E that byte is `core_rdata`, which is taken at `core_addr`.
- R3: A write window exists only while chip select and write enable are both low. It commits exactly once, when the window ends. The committed data is the last data sampled inside the window. Data that changes after either strobe rises is not written. Write enable low with chip select high writes nothing.
- R4: Addresses 0x0E to 0x3F hold host-written bytes and read them back. Writes to them produce no `wr_valid` pulse.
- R5: A committed write to an address from 0x00 to 0x0D gives a single-cycle `wr_valid` pulse with `wr_addr`, `wr_data` and `wr_kind`. The class codes are: 0 for 0x0,0x1,0x2,0x4,0x6,0x8,0x9,0xA; 1 for 0x3,0x5,0x7; 2 for 0xB (the command byte); 3 for 0xC,0xD.
- R6: When write enable falls during an active read, `bus_dq_oe` drops within SYNC_STAGES+1 cycles, even though output enable is still low.
- R7: While `pwr_ok` is low the bus is not driven and no write commits. A write window that overlaps any cycle of bad power is discarded, even if power recovers before the window ends.
- R8: After `pwr_ok` rises, the port stays protected for PG_TICKS clock cycles. After that, reads are driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_addr | input | 6 | Host register address |
| bus_dq_i | input | 8 | Data from host pad |
| bus_dq_o | output | 8 | Data toward host pad |
| bus_dq_oe | output | 1 | Pad output enable |
| pwr_ok | input | 1 | Supply within tolerance |
| core_addr | output | 6 | Synchronized address for core reads |
| core_rdata | input | 8 | Core byte for the address on core_addr |
| wr_valid | output | 1 | One-cycle core write strobe |
| wr_kind | output | 2 | Register class of the write |
| wr_addr | output | 6 | Address of the core write |
| wr_data | output | 8 | Data of the core write |

## Verification
Faults in the window tracking or in the capture register show up at the ports as a missing, doubled or wrong-data `wr_valid` pulse. A RAM fault shows up as a wrong readback. Both appear within SYNC_STAGES+1 cycles of the window closing or of the read strobes settling. A stuck protection state appears as `bus_dq_oe` driven during bad power, or staying low for more than PG_TICKS cycles after power returns. A wrong abort flag shows up as a write that lands after a power glitch.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int RAM_BASE  = 14;
    localparam int RAM_DEPTH = NUM_REGS - RAM_BASE;

    typedef enum logic [1:0] {
        KIND_TIME  = 2'd0,
        KIND_ALARM = 2'd1,
        KIND_CMD   = 2'd2,
        KIND_WDOG  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_beat_t;

    function automatic logic is_user_ram(input logic [ADDR_W-1:0] a);
        return a >= ADDR_W'(RAM_BASE);
    endfunction

    function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
        case (a[3:0])
            4'h3, 4'h5, 4'h7: return KIND_ALARM;
            4'hB:             return KIND_CMD;
            4'hC, 4'hD:       return KIND_WDOG;
            default:          return KIND_TIME;
        endcase
    endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_pwr_gate.sv
module hbus_pwr_gate #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    output logic protect
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] DONE = CW'(TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) cnt <= '0;
        else if (cnt != DONE) cnt <= cnt + 1'b1;
    end

    assign protect = (cnt != DONE);

    // R7
    pwr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> protect);

    // R8
    pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_ok) |=> protect);
endmodule

// File: rtl/hbus_user_ram.sv
module hbus_user_ram
    import hbus_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int BASE = RAM_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_idx, rd_idx;

    assign wr_idx = wr_addr - BASE_A;
    assign rd_idx = rd_addr - BASE_A;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (rd_addr >= BASE_A) ? mem[rd_idx] : '0;

    // R4
    ram_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr >= BASE_A));
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport
    import hbus_pkg::*;
#(
    parameter int PG_TICKS = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq_i,
    output logic [DATA_W-1:0] bus_dq_o,
    output logic              bus_dq_oe,
    input  logic              pwr_ok,
    output logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              wr_valid,
    output logic [1:0]        wr_kind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int BEAT_W = ADDR_W + DATA_W;

    strobe_t   st_raw, st_s;
    bus_beat_t beat_raw, beat_s, cap;
    logic      protect;
    logic      win_s, win_q, abort_q, commit, rd_req, ram_we;
    logic [DATA_W-1:0] ram_q, rd_data_q;
    logic      rd_oe_q;

    assign st_raw   = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};
    assign beat_raw = '{addr: bus_addr, data: bus_dq_i};

    // Strobes and the address/data beat share one pipeline depth so they stay aligned
    hbus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strobe_sync (
        .clk(clk), .rst(rst), .d(st_raw), .q(st_s)
    );

    hbus_sync #(.W(BEAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_beat_sync (
        .clk(clk), .rst(rst), .d(beat_raw), .q(beat_s)
    );

    hbus_pwr_gate #(.TICKS(PG_TICKS)) u_pwr (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .protect(protect)
    );

    assign win_s  = !st_s.cs_n && !st_s.we_n;
    assign rd_req = !st_s.cs_n && !st_s.oe_n && st_s.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= 1'b0;
            abort_q <= 1'b0;
            cap     <= '0;
        end else begin
            win_q <= win_s;
            if (win_s) cap <= beat_s;
            if (!win_s) abort_q <= 1'b0;
            else if (protect) abort_q <= 1'b1;
        end
    end

    // Commit once on the detected end of the write window
    assign commit   = win_q && !win_s && !abort_q && !protect;
    assign ram_we   = commit && is_user_ram(cap.addr);
    assign wr_valid = commit && !is_user_ram(cap.addr);
    assign wr_addr  = cap.addr;
    assign wr_data  = cap.data;
    assign wr_kind  = kind_of(cap.addr);

    hbus_user_ram #(.DEPTH(RAM_DEPTH), .BASE(RAM_BASE)) u_ram (
        .clk(clk), .rst(rst),
        .wr_en(ram_we), .wr_addr(cap.addr), .wr_data(cap.data),
        .rd_addr(beat_s.addr), .rd_data(ram_q)
    );

    assign core_addr = beat_s.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe_q   <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_oe_q   <= rd_req && !protect;
            rd_data_q <= is_user_ram(beat_s.addr) ? ram_q : core_rdata;
        end
    end

    assign bus_dq_oe = rd_oe_q;
    assign bus_dq_o  = rd_oe_q ? rd_data_q : '0;

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_dq_oe |-> ($past(!st_s.cs_n) && $past(!st_s.oe_n)));

    // R3
    win_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(win_s) && !win_s));

    // R5
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R6
    we_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_s.we_n) |=> !bus_dq_oe);

    // R7
    prot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        protect |=> !bus_dq_oe);
endmodule

// File: tb/hbus_regport_tb_top.sv
module hbus_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] dq_i = '0;
    logic [7:0] dq_o;
    logic       dq_oe;
    logic       pwr_ok = 1'b1;
    logic [5:0] core_addr;
    logic [7:0] core_rdata;
    logic       wr_valid;
    logic [1:0] wr_kind;
    logic [5:0] wr_addr;
    logic [7:0] wr_data;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    assign core_rdata = {2'b01, core_addr};

    hbus_regport #(.PG_TICKS(16), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_dq_i(dq_i),
        .bus_dq_o(dq_o), .bus_dq_oe(dq_oe),
        .pwr_ok(pwr_ok),
        .core_addr(core_addr), .core_rdata(core_rdata),
        .wr_valid(wr_valid), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [1:0] ref_kind(input logic [5:0] a);
        if (a == 6'h03 || a == 6'h05 || a == 6'h07) return 2'd1;
        if (a == 6'h0B) return 2'd2;
        if (a == 6'h0C || a == 6'h0D) return 2'd3;
        return 2'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fin();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && wr_valid) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R5/R7 unexpected write pulse actual=%0h expected=none",
                             {wr_kind, wr_addr, wr_data});
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check("R5 write pulse kind/addr/data", {16'h0, wr_kind, wr_addr, wr_data}, {16'h0, e});
                end
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input bit expect_pulse);
        if (expect_pulse && a < 6'h0E) exp_q.push_back({ref_kind(a), a, d});
        @(posedge clk); #2;
        addr = a; dq_i = d; cs_n = 1'b0; we_n = 1'b0;
        repeat (4) @(posedge clk);
        #2; cs_n = 1'b1; we_n = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    task automatic bus_read(input logic [5:0] a, input bit exp_drive, input logic [7:0] exp, input string tag);
        @(posedge clk); #2;
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(tag, {31'h0, dq_oe}, {31'h0, exp_drive});
        if (exp_drive) check(tag, {24'h0, dq_o}, {24'h0, exp});
        @(posedge clk); #2;
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        fin();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 oe in reset", {31'h0, dq_oe}, 32'h0);
        check("R1 wr_valid in reset", {31'h0, wr_valid}, 32'h0);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check("R1 oe after reset", {31'h0, dq_oe}, 32'h0);
        repeat (40) @(posedge clk);
        bus_read(6'h2A, 1'b1, 8'h00, "R1 ram cleared");
        bus_read(6'h0E, 1'b1, 8'h00, "R1 ram cleared low edge");

        // R4 storage bytes, including both ends
        bus_write(6'h0E, 8'h3C, 1'b0);
        bus_write(6'h3F, 8'hA5, 1'b0);
        bus_write(6'h30, 8'h11, 1'b0);
        bus_read(6'h0E, 1'b1, 8'h3C, "R4 readback 0x0E");
        bus_read(6'h3F, 1'b1, 8'hA5, "R4 readback 0x3F");
        bus_read(6'h30, 1'b1, 8'h11, "R4 readback 0x30");

        // R5 every core address gives one pulse with its class
        for (int i = 0; i < 14; i++) bus_write(6'(i), 8'(8'h80 + i), 1'b1);
        check("R5 all pulses seen", exp_q.size(), 0);

        // R2 core reads
        bus_read(6'h05, 1'b1, 8'h45, "R2 core read 0x05");
        bus_read(6'h0D, 1'b1, 8'h4D, "R2 core read 0x0D");

        // R3 window is the overlap; last in-window data is committed
        @(posedge clk); #2;
        addr = 6'h20; dq_i = 8'hA1; cs_n = 1'b0;
        repeat (3) @(posedge clk); #2 we_n = 1'b0;
        repeat (3) @(posedge clk); #2 dq_i = 8'hB2;
        repeat (4) @(posedge clk); #2 cs_n = 1'b1; dq_i = 8'hC3;
        repeat (3) @(posedge clk); #2 we_n = 1'b1;
        repeat (5) @(posedge clk);
        bus_read(6'h20, 1'b1, 8'hB2, "R3 overlap data");
        @(posedge clk); #2;
        addr = 6'h20; dq_i = 8'h77; we_n = 1'b0;
        repeat (4) @(posedge clk); #2 we_n = 1'b1;
        repeat (5) @(posedge clk);
        bus_read(6'h20, 1'b1, 8'hB2, "R3 write enable alone ignored");

        // R6 write enable overrides an active read
        @(posedge clk); #2;
        addr = 6'h0B; cs_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R6 read driven first", {31'h0, dq_oe}, 32'h1);
        check("R6 read data first", {24'h0, dq_o}, 32'h4B);
        @(posedge clk); #2;
        exp_q.push_back({2'd2, 6'h0B, 8'h5A});
        dq_i = 8'h5A; we_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 bus released", {31'h0, dq_oe}, 32'h0);
        @(posedge clk); #2;
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(posedge clk);
        check("R6 command write seen", exp_q.size(), 0);

        // R7 bad power: everything ignored
        @(posedge clk); #2 pwr_ok = 1'b0;
        repeat (2) @(posedge clk);
        bus_write(6'h03, 8'h99, 1'b0);
        bus_write(6'h30, 8'hEE, 1'b0);
        bus_read(6'h30, 1'b0, 8'h00, "R7 no drive while power bad");
        @(posedge clk); #2 pwr_ok = 1'b1;
        repeat (30) @(posedge clk);
        // R7 a window that spans a power glitch is discarded
        @(posedge clk); #2;
        addr = 6'h30; dq_i = 8'hDD; cs_n = 1'b0; we_n = 1'b0;
        repeat (3) @(posedge clk); #2 pwr_ok = 1'b0;
        @(posedge clk); #2 pwr_ok = 1'b1;
        repeat (30) @(posedge clk); #2 cs_n = 1'b1; we_n = 1'b1;
        repeat (5) @(posedge clk);
        bus_read(6'h30, 1'b1, 8'h11, "R7 glitched window dropped");

        // R8 protection held after power returns
        @(posedge clk); #2 pwr_ok = 1'b0;
        repeat (2) @(posedge clk); #2;
        pwr_ok = 1'b1; addr = 6'h30; cs_n = 1'b0; oe_n = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R8 still protected", {31'h0, dq_oe}, 32'h0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8 driven after hold", {31'h0, dq_oe}, 32'h1);
        check("R8 data after hold", {24'h0, dq_o}, 32'h11);
        @(posedge clk); #2 cs_n = 1'b1; oe_n = 1'b1;
        repeat (5) @(posedge clk);

        check("R5 scoreboard drained", exp_q.size(), 0);
        fin();
    end
endmodule